// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block keeps track of the operating mode of a communication device and turns that mode into clock-gating enables and reset strobes for the rest of the chip. The mode comes from five sources: a hardware reset pin that is sampled on the running clock, a software-reset bit and a start bit in a host command register, an oscillator-enable pin, and a chip-enable pin. The possible modes are reset, standby, active, freeze and sleep. A device always leaves reset into standby. It moves to active only when the host writes the start bit. From standby it can drop into freeze or sleep. From freeze or sleep it returns only through another reset.

The outputs are gating enables for the CPU clock, the general-purpose timer and the codec interface, and a run enable for the protocol engine. There are also two clear strobes: one for registers that only a hardware reset may clear, and one for registers that either kind of reset clears. A small host register bank uses these strobes and holds one register of each reset class, one register that no reset touches, and a status word. The status word carries the mode, a sticky refusal flag and an interrupt flag. The interrupt flag is cleared by a status read, except while the device sleeps.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While the hardware reset pin is sampled high, the mode becomes RESET (code 0) and `hw_clr_o` and `any_clr_o` are both high. When the reset ends, the hardware-class register (address 1) holds 0xA5 and the either-class register (address 2) holds 0x3C.
- R2: A software reset returns address 2 to 0x3C and leaves address 1 unchanged. The I/O register (address 3) keeps its value through both kinds of reset and changes only when it is written.
- R3: A hardware reset keeps the mode at RESET for max(pulse length, HOLD_CYC) cycles. HOLD_CYC defaults to 10. A shorter pulse is stretched to HOLD_CYC.
- R4: When a reset ends, the mode is STANDBY (code 1). In STANDBY the CPU clock, timer and codec enables are 1 and `proto_run_o` is 0.
- R5: A host write of 1 to bit 1 of address 0 (start) moves STANDBY to ACTIVE (code 2) two clock edges after the write edge, and `proto_run_o` goes to 1. A start write in any other mode has no effect.
- R6: A host write of 1 to bit 0 of address 0 (software reset) produces exactly one RESET cycle, starting two edges after the write edge, with `any_clr_o`=1 and `hw_clr_o`=0. STANDBY follows. A software reset that arrives together with start wins over start.
- R7: In STANDBY or FREEZE, a low `osc_en_i` gives SLEEP (code 4) on the next edge. In SLEEP all four enables are 0.
- R8: In STANDBY, a low `chip_en_i` with `osc_en_i` high gives FREEZE (code 3). In FREEZE the CPU clock and timer enables are 1 and the codec and protocol enables are 0. When both pins are low in STANDBY, sleep takes priority.
- R9: SLEEP and FREEZE ignore the return of the enable pins and ignore start writes. Only a hardware or software reset leaves them, and the reset leads to STANDBY.
- R10: In ACTIVE, a low `osc_en_i` or `chip_en_i` leaves the mode ACTIVE and sets the refusal flag (`err_o`, status bit 6). The flag stays set through software resets and is cleared only by a hardware reset.
- R11: The status word at address 0 reads {irq, err, 3'b000, mode[2:0]}. `irq_evt_i` sets irq (bit 7, `irq_o`). A read of address 0 with `rd_en_i` clears irq outside SLEEP but not in SLEEP, and any reset clears it. Reads of addresses 1 to 3 return the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| hw_rst_i | input | 1 | Hardware reset pin, active high, sampled on the clock |
| osc_en_i | input | 1 | Oscillator enable; low requests sleep |
| chip_en_i | input | 1 | Chip enable; low requests freeze |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_en_i | input | 1 | Host read strobe (a read of address 0 clears irq) |
| rd_addr_i | input | 2 | Host read address |
| rd_data_o | output | 8 | Host read data, combinational |
| irq_evt_i | input | 1 | Interrupt event, sets irq |
| irq_o | output | 1 | Interrupt request |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en_o | output | 1 | CPU clock gating enable |
| timer_en_o | output | 1 | General-purpose timer enable |
| codec_en_o | output | 1 | Codec interface enable |
| proto_run_o | output | 1 | Protocol engine run enable |
| hw_clr_o | output | 1 | Clear strobe for the hardware-only register class |
| any_clr_o | output | 1 | Clear strobe for the either-reset register class |
| err_o | output | 1 | Sticky flag: a low-power request was refused |

## Verification
A wrong mode value reaches the ports on the same cycle it appears. It shows up on `mode_o` and, through the mode decode, on the four enables. The bench's cycle model catches it at the first falling edge after the bad transition. A hold counter that is off by one shows as a RESET period one cycle too long or too short, and it becomes visible when STANDBY arrives. A wrong clear or refusal path stays hidden until the host reads the register or status word involved, or until `err_o`/`irq_o` differ from the model. For that reason the bench reads each register class after every kind of reset.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_RESET   = 3'd0,
        PM_STANDBY = 3'd1,
        PM_ACTIVE  = 3'd2,
        PM_FREEZE  = 3'd3,
        PM_SLEEP   = 3'd4
    } pm_mode_e;

    localparam logic [1:0] ADR_CMD_STAT = 2'd0;
    localparam logic [1:0] ADR_CFG_HW   = 2'd1;
    localparam logic [1:0] ADR_CFG_ANY  = 2'd2;
    localparam logic [1:0] ADR_IOX      = 2'd3;

    localparam int unsigned BIT_SWRST  = 0;
    localparam int unsigned BIT_START  = 1;
    localparam int unsigned BIT_ERR    = 6;
    localparam int unsigned BIT_IRQ    = 7;

endpackage

// File: rtl/pmc_cmd.sv
module pmc_cmd
    import pmc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              hw_rst_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              swrst_o,
    output logic              start_o
);

    typedef struct packed {
        logic swrst;
        logic start;
    } cmd_t;

    cmd_t c_d, c_q;
    logic cmd_hit;

    always_comb begin
        cmd_hit   = wr_en_i && (wr_addr_i == ADR_CMD_STAT);
        c_d.swrst = cmd_hit && wr_data_i[BIT_SWRST];
        c_d.start = cmd_hit && wr_data_i[BIT_START];
        if (hw_rst_i) begin
            c_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        c_q <= c_d;
    end

    assign swrst_o = c_q.swrst;
    assign start_o = c_q.start;

    AST_SWRST_FROM_WRITE: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        $rose(swrst_o) |-> $past(wr_en_i) && ($past(wr_addr_i) == ADR_CMD_STAT)) // R6
        else $error("software reset pulse without a command write");

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 10
) (
    input  logic     clk_i,
    input  logic     hw_rst_i,
    input  logic     osc_en_i,
    input  logic     chip_en_i,
    input  logic     swrst_i,
    input  logic     start_i,
    output pm_mode_e mode_o,
    output logic     hw_clr_o,
    output logic     any_clr_o,
    output logic     err_o
);

    localparam int unsigned CNT_W  = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    typedef struct packed {
        pm_mode_e         mode;
        logic [CNT_W-1:0] cnt;
        logic             hwsrc;
        logic             err;
    } fsm_t;

    fsm_t s_d, s_q;
    logic in_hw;
    logic want_sleep;
    logic want_frz;

    always_comb begin
        s_d        = s_q;
        in_hw      = (s_q.mode == PM_RESET) && s_q.hwsrc;
        want_sleep = !osc_en_i;
        want_frz   = !chip_en_i;

        if (hw_rst_i) begin
            s_d.mode  = PM_RESET;
            s_d.hwsrc = 1'b1;
            if (in_hw) begin
                s_d.cnt = (s_q.cnt < HOLD_V) ? s_q.cnt + ONE_V : s_q.cnt;
            end else begin
                s_d.cnt = ONE_V;
            end
        end else if (in_hw && (s_q.cnt < HOLD_V)) begin
            s_d.cnt = s_q.cnt + ONE_V;
        end else if (swrst_i) begin
            s_d.mode  = PM_RESET;
            s_d.hwsrc = 1'b0;
            s_d.cnt   = '0;
        end else begin
            s_d.hwsrc = 1'b0;
            s_d.cnt   = '0;
            unique case (s_q.mode)
                PM_RESET:   s_d.mode = PM_STANDBY;
                PM_STANDBY: begin
                    if (want_sleep) begin
                        s_d.mode = PM_SLEEP;
                    end else if (want_frz) begin
                        s_d.mode = PM_FREEZE;
                    end else if (start_i) begin
                        s_d.mode = PM_ACTIVE;
                    end
                end
                PM_ACTIVE: begin
                    if (want_sleep || want_frz) begin
                        s_d.err = 1'b1;
                    end
                end
                PM_FREEZE: begin
                    if (want_sleep) begin
                        s_d.mode = PM_SLEEP;
                    end
                end
                PM_SLEEP:   s_d.mode = PM_SLEEP;
                default:    s_d.mode = PM_RESET;
            endcase
        end

        if (in_hw) begin
            s_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign mode_o    = s_q.mode;
    assign hw_clr_o  = in_hw;
    assign any_clr_o = (s_q.mode == PM_RESET);
    assign err_o     = s_q.err;

    AST_HOLD_MIN: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        $fell(hw_clr_o) |-> ($past(s_q.cnt) >= HOLD_V)) // R3
        else $error("hardware reset released before the hold count");

    AST_ACTIVE_ENTRY: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        (s_q.mode == PM_ACTIVE && $past(s_q.mode) != PM_ACTIVE)
            |-> ($past(s_q.mode) == PM_STANDBY && $past(start_i))) // R5
        else $error("active entered from a mode other than standby");

    AST_ACTIVE_REFUSE: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        (s_q.mode == PM_ACTIVE) |=> (s_q.mode == PM_ACTIVE || s_q.mode == PM_RESET)) // R10
        else $error("active left without a reset");

    AST_LOWPWR_HELD: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        (s_q.mode == PM_SLEEP && !swrst_i) |=> (s_q.mode == PM_SLEEP)) // R9
        else $error("sleep left without a reset");

    AST_FREEZE_HELD: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        (s_q.mode == PM_FREEZE && !swrst_i)
            |=> (s_q.mode == PM_FREEZE || s_q.mode == PM_SLEEP)) // R9
        else $error("freeze left without a reset");

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        (s_q.err && !in_hw) |=> s_q.err) // R10
        else $error("refusal flag lost without a hardware reset");

endmodule

// File: rtl/pmc_reg_bank.sv
module pmc_reg_bank
    import pmc_pkg::*;
#(
    parameter int unsigned      DATA_W  = 8,
    parameter logic [DATA_W-1:0] HW_DEF  = 8'hA5,
    parameter logic [DATA_W-1:0] ANY_DEF = 8'h3C
) (
    input  logic              clk_i,
    input  logic              hw_rst_i,
    input  logic              hw_clr_i,
    input  logic              any_clr_i,
    input  pm_mode_e          mode_i,
    input  logic              err_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    input  logic              irq_evt_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] cfg_hw;
        logic [DATA_W-1:0] cfg_any;
        logic [DATA_W-1:0] iox;
        logic              irq;
    } bank_t;

    bank_t b_d, b_q;
    logic  in_sleep;
    logic  stat_rd;
    logic  wr_hw, wr_any, wr_iox;
    logic [DATA_W-1:0] status;

    always_comb begin
        b_d      = b_q;
        in_sleep = (mode_i == PM_SLEEP);
        stat_rd  = rd_en_i && (rd_addr_i == ADR_CMD_STAT);
        wr_hw    = wr_en_i && (wr_addr_i == ADR_CFG_HW);
        wr_any   = wr_en_i && (wr_addr_i == ADR_CFG_ANY);
        wr_iox   = wr_en_i && (wr_addr_i == ADR_IOX);

        if (hw_clr_i) begin
            b_d.cfg_hw = HW_DEF;
        end else if (wr_hw) begin
            b_d.cfg_hw = wr_data_i;
        end

        if (any_clr_i) begin
            b_d.cfg_any = ANY_DEF;
        end else if (wr_any) begin
            b_d.cfg_any = wr_data_i;
        end

        if (wr_iox) begin
            b_d.iox = wr_data_i;
        end

        if (any_clr_i) begin
            b_d.irq = 1'b0;
        end else if (irq_evt_i) begin
            b_d.irq = 1'b1;
        end else if (stat_rd && !in_sleep) begin
            b_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        b_q <= b_d;
    end

    always_comb begin
        status          = '0;
        status[2:0]     = mode_i;
        status[BIT_ERR] = err_i;
        status[BIT_IRQ] = b_q.irq;
        unique case (rd_addr_i)
            ADR_CMD_STAT: rd_data_o = status;
            ADR_CFG_HW:   rd_data_o = b_q.cfg_hw;
            ADR_CFG_ANY:  rd_data_o = b_q.cfg_any;
            default:      rd_data_o = b_q.iox;
        endcase
    end

    assign irq_o = b_q.irq;

    AST_IOX_RETAIN: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        !(wr_en_i && wr_addr_i == ADR_IOX) |=> $stable(b_q.iox)) // R2
        else $error("I/O register changed without a write");

    AST_HWCLASS_SW: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        (any_clr_i && !hw_clr_i && !(wr_en_i && wr_addr_i == ADR_CFG_HW))
            |=> $stable(b_q.cfg_hw)) // R2
        else $error("hardware-class register disturbed by software reset");

    AST_ANY_DEFAULT: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        any_clr_i |=> (b_q.cfg_any == ANY_DEF)) // R1
        else $error("either-class register missed its default");

    AST_IRQ_SLEEP: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        (b_q.irq && mode_i == PM_SLEEP && !any_clr_i) |=> b_q.irq) // R7
        else $error("interrupt cleared during sleep");

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 10,
    parameter int unsigned DATA_W   = 8,
    parameter logic [DATA_W-1:0] HW_DEF  = 8'hA5,
    parameter logic [DATA_W-1:0] ANY_DEF = 8'h3C
) (
    input  logic              clk_i,
    input  logic              hw_rst_i,
    input  logic              osc_en_i,
    input  logic              chip_en_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              irq_evt_i,
    output logic              irq_o,
    output logic [2:0]        mode_o,
    output logic              cpu_clk_en_o,
    output logic              timer_en_o,
    output logic              codec_en_o,
    output logic              proto_run_o,
    output logic              hw_clr_o,
    output logic              any_clr_o,
    output logic              err_o
);

    pm_mode_e mode;
    logic     swrst;
    logic     start;
    logic     hw_clr;
    logic     any_clr;
    logic     err;

    pmc_cmd #(
        .DATA_W (DATA_W)
    ) i_cmd (
        .clk_i     (clk_i),
        .hw_rst_i  (hw_rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .swrst_o   (swrst),
        .start_o   (start)
    );

    pmc_mode_fsm #(
        .HOLD_CYC (HOLD_CYC)
    ) i_fsm (
        .clk_i     (clk_i),
        .hw_rst_i  (hw_rst_i),
        .osc_en_i  (osc_en_i),
        .chip_en_i (chip_en_i),
        .swrst_i   (swrst),
        .start_i   (start),
        .mode_o    (mode),
        .hw_clr_o  (hw_clr),
        .any_clr_o (any_clr),
        .err_o     (err)
    );

    pmc_reg_bank #(
        .DATA_W  (DATA_W),
        .HW_DEF  (HW_DEF),
        .ANY_DEF (ANY_DEF)
    ) i_bank (
        .clk_i     (clk_i),
        .hw_rst_i  (hw_rst_i),
        .hw_clr_i  (hw_clr),
        .any_clr_i (any_clr),
        .mode_i    (mode),
        .err_i     (err),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .irq_evt_i (irq_evt_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

    always_comb begin
        mode_o       = mode;
        cpu_clk_en_o = (mode != PM_SLEEP);
        timer_en_o   = (mode != PM_SLEEP);
        codec_en_o   = (mode == PM_STANDBY) || (mode == PM_ACTIVE);
        proto_run_o  = (mode == PM_ACTIVE);
        hw_clr_o     = hw_clr;
        any_clr_o    = any_clr;
        err_o        = err;
    end

    AST_PROTO_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (hw_rst_i)
        $rose(proto_run_o) |-> $past(codec_en_o) && !$past(proto_run_o)) // R5
        else $error("protocol enabled without passing standby");

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

    localparam int HOLD = 10;

    logic       clk = 1'b0;
    logic       hw_rst = 1'b1;
    logic       osc_en = 1'b1;
    logic       chip_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic       irq_evt = 1'b0;
    logic [7:0] rd_data;
    logic       irq_o, cpu_en, tmr_en, cdc_en, prun, hwclr, anyclr, err_o;
    logic [2:0] mode_o;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural model state
    int m_mode = 0, m_cnt = 0, m_hw = 0, m_err = 0, m_swp = 0, m_stp = 0;
    int m_cfgh = 0, m_cfga = 0, m_iox = 0, m_irq = 0;
    bit m_iox_known = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk_i(clk), .hw_rst_i(hw_rst), .osc_en_i(osc_en), .chip_en_i(chip_en),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .irq_evt_i(irq_evt), .irq_o(irq_o), .mode_o(mode_o),
        .cpu_clk_en_o(cpu_en), .timer_en_o(tmr_en), .codec_en_o(cdc_en),
        .proto_run_o(prun), .hw_clr_o(hwclr), .any_clr_o(anyclr), .err_o(err_o)
    );

    task automatic check(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // model step at every rising edge, inputs are stable here
    always @(posedge clk) begin : mdl
        int n_mode, n_cnt, n_hw, n_err, n_irq, n_cfgh, n_cfga;
        bit in_hw, in_rst, lowreq;
        in_hw  = (m_mode == 0) && (m_hw == 1);
        in_rst = (m_mode == 0);
        lowreq = !osc_en || !chip_en;
        n_mode = m_mode; n_cnt = m_cnt; n_hw = m_hw; n_err = m_err;
        if (hw_rst) begin
            n_mode = 0; n_hw = 1;
            n_cnt = in_hw ? ((m_cnt < HOLD) ? m_cnt + 1 : m_cnt) : 1;
        end else if (in_hw && m_cnt < HOLD) begin
            n_cnt = m_cnt + 1;
        end else if (m_swp == 1) begin
            n_mode = 0; n_hw = 0; n_cnt = 0;
        end else begin
            n_hw = 0; n_cnt = 0;
            if (m_mode == 0) n_mode = 1;
            else if (m_mode == 1) begin
                if (!osc_en) n_mode = 4;
                else if (!chip_en) n_mode = 3;
                else if (m_stp == 1) n_mode = 2;
            end else if (m_mode == 2) begin
                if (lowreq) n_err = 1;
            end else if (m_mode == 3) begin
                if (!osc_en) n_mode = 4;
            end
        end
        if (in_hw) n_err = 0;
        n_cfgh = in_hw ? 8'hA5 : ((wr_en && wr_addr == 2'd1) ? int'(wr_data) : m_cfgh);
        n_cfga = in_rst ? 8'h3C : ((wr_en && wr_addr == 2'd2) ? int'(wr_data) : m_cfga);
        if (wr_en && wr_addr == 2'd3) begin
            m_iox = int'(wr_data); m_iox_known = 1'b1;
        end
        if (in_rst) n_irq = 0;
        else if (irq_evt) n_irq = 1;
        else if (rd_en && rd_addr == 2'd0 && m_mode != 4) n_irq = 0;
        else n_irq = m_irq;
        m_swp = (!hw_rst && wr_en && wr_addr == 2'd0 && wr_data[0]) ? 1 : 0;
        m_stp = (!hw_rst && wr_en && wr_addr == 2'd0 && wr_data[1]) ? 1 : 0;
        m_mode = n_mode; m_cnt = n_cnt; m_hw = n_hw; m_err = n_err;
        m_cfgh = n_cfgh; m_cfga = n_cfga; m_irq = n_irq;
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            int exp_rd;
            check(int'(mode_o), m_mode, "R3/R4/R5/R7/R8/R9 mode");
            check(int'(cpu_en), (m_mode != 4) ? 1 : 0, "R7/R8 cpu_clk_en");
            check(int'(tmr_en), (m_mode != 4) ? 1 : 0, "R7/R8 timer_en");
            check(int'(cdc_en), (m_mode == 1 || m_mode == 2) ? 1 : 0, "R4/R8 codec_en");
            check(int'(prun), (m_mode == 2) ? 1 : 0, "R5 proto_run");
            check(int'(hwclr), (m_mode == 0 && m_hw == 1) ? 1 : 0, "R1/R6 hw_clr");
            check(int'(anyclr), (m_mode == 0) ? 1 : 0, "R1/R6 any_clr");
            check(int'(err_o), m_err, "R10 err");
            check(int'(irq_o), m_irq, "R11 irq");
            case (rd_addr)
                2'd0: exp_rd = (m_irq << 7) | (m_err << 6) | m_mode;
                2'd1: exp_rd = m_cfgh;
                2'd2: exp_rd = m_cfga;
                default: exp_rd = m_iox_known ? m_iox : int'(rd_data);
            endcase
            check(int'(rd_data), exp_rd, "R11 rd_data");
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, input int exp, input string req);
        rd_addr = a;
        #1;
        check(int'(rd_data), exp, req);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        // R3: short power-up pulse of three cycles is stretched
        repeat (3) step();
        cmp_on = 1'b1;
        check(int'(mode_o), 0, "R1 reset mode");
        check(int'(hwclr) + int'(anyclr), 2, "R1 both strobes");
        hw_rst = 1'b0;
        repeat (HOLD - 3) step();
        check(int'(mode_o), 0, "R3 still held in reset");
        step();
        check(int'(mode_o), 1, "R4 standby after hold");
        check(int'(prun), 0, "R4 protocol halted");
        host_rd(2'd1, 8'hA5, "R1 hw-class default");
        host_rd(2'd2, 8'h3C, "R1 either-class default");

        host_wr(2'd1, 8'h11);
        host_wr(2'd2, 8'h22);
        host_wr(2'd3, 8'h33);

        // R5: start moves standby to active
        host_wr(2'd0, 8'h02);
        check(int'(mode_o), 1, "R5 not yet active");
        step();
        check(int'(mode_o), 2, "R5 active");
        check(int'(prun), 1, "R5 protocol runs");

        // R10: low-power request refused in active
        osc_en = 1'b0;
        step();
        check(int'(mode_o), 2, "R10 sleep refused");
        check(int'(err_o), 1, "R10 error flag");
        osc_en = 1'b1;
        chip_en = 1'b0;
        step();
        chip_en = 1'b1;
        check(int'(mode_o), 2, "R10 freeze refused");

        // R6: software reset, one RESET cycle
        host_wr(2'd0, 8'h01);
        step();
        check(int'(mode_o), 0, "R6 reset cycle");
        check(int'(hwclr), 0, "R6 no hw strobe");
        step();
        check(int'(mode_o), 1, "R6 back in standby");
        host_rd(2'd2, 8'h3C, "R2 either-class cleared");
        host_rd(2'd1, 8'h11, "R2 hw-class kept");
        host_rd(2'd3, 8'h33, "R2 iox kept");
        check(int'(err_o), 1, "R10 err survives sw reset");

        // R8: freeze, then sleep from freeze
        chip_en = 1'b0;
        step();
        check(int'(mode_o), 3, "R8 freeze");
        check(int'(cpu_en) + int'(tmr_en), 2, "R8 cpu/timer run");
        host_wr(2'd0, 8'h02);
        step();
        check(int'(mode_o), 3, "R9 start ignored in freeze");
        osc_en = 1'b0;
        step();
        check(int'(mode_o), 4, "R7 sleep from freeze");

        // R7/R11: irq not cleared by status read in sleep
        irq_evt = 1'b1;
        step();
        irq_evt = 1'b0;
        rd_addr = 2'd0; rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        check(int'(irq_o), 1, "R7 irq held in sleep");
        osc_en = 1'b1; chip_en = 1'b1;
        repeat (3) step();
        check(int'(mode_o), 4, "R9 sleep held");

        // R9: software reset leaves sleep
        host_wr(2'd0, 8'h01);
        repeat (2) step();
        check(int'(mode_o), 1, "R9 standby after reset");
        irq_evt = 1'b1;
        step();
        irq_evt = 1'b0;
        check(int'(irq_o), 1, "R11 irq set");
        rd_addr = 2'd0; rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        check(int'(irq_o), 0, "R11 irq cleared by read");

        // R8: both low in standby gives sleep
        osc_en = 1'b0; chip_en = 1'b0;
        step();
        check(int'(mode_o), 4, "R8 sleep priority");
        osc_en = 1'b1; chip_en = 1'b1;

        // R3/R1: long hardware reset of 15 cycles
        hw_rst = 1'b1;
        repeat (15) step();
        hw_rst = 1'b0;
        check(int'(mode_o), 0, "R3 long reset");
        step();
        check(int'(mode_o), 1, "R3 long pulse not stretched");
        host_rd(2'd1, 8'hA5, "R1 hw-class default again");
        host_rd(2'd3, 8'h33, "R2 iox survives hw reset");
        check(int'(err_o), 0, "R10 err cleared by hw reset");

        // R6: reset and start in one write, reset wins
        host_wr(2'd0, 8'h03);
        step();
        check(int'(mode_o), 0, "R6 reset beats start");
        step();
        check(int'(mode_o), 1, "R6 standby after combined write");
        repeat (3) step();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule